// File: doc/BRIEF.md
# FIFO Access Window for a Memory-Mapped Bus

This block lets a bus master exchange data with on-chip logic through a single data address. It holds two queues. Writes to the data address feed an outbound queue that the logic side drains with a valid/ready handshake. Reads of the data address take entries from an inbound queue that the logic side fills with its own valid/ready handshake. The address never advances between accesses. Every access to the data address moves on to the next entry, so software streams a block of words by hitting the same location repeatedly.

Beside the data address sit a status word, a read-only copy of the configured queue depth, and one used-word count for each queue. A read of the data address while the inbound queue is empty returns zero and raises a sticky underflow flag. A write while the outbound queue is full is discarded and raises a sticky overflow flag. Software clears either flag by writing a one to its bit. Everything runs on one clock.

Top module: `mm_fifo_window`

## Requirements
- R1: After reset both queues are empty, `dn_valid` is 0, `up_ready` is 1, `bus_rdata` is 0, and a status read returns 0x9.
- R2: A bus write to address 0 with the outbound queue not full appends `bus_wdata`. `dn_valid` is high exactly when that queue holds a word. `dn_data` shows the oldest word and stays unchanged until it is taken, which happens on a clock edge with `dn_valid` and `dn_ready` both high.
- R3: A bus read of address 0 with the inbound queue not empty removes the oldest word pushed through `up_data`/`up_valid`, and `bus_rdata` shows it after the next rising edge. `up_ready` is high exactly when the inbound queue holds fewer than DEPTH words.
- R4: Status at address 1 is laid out as follows. Bit 0 is set when the inbound queue is empty. Bit 1 is set when the outbound queue is full. Bit 2 is set when the inbound queue is full. Bit 3 is set when the outbound queue is empty. Bit 8 is the underflow flag and bit 9 is the overflow flag. All other bits read 0.
- R5: Address 2 reads DEPTH. Address 3 reads the inbound used count and address 4 reads the outbound used count. Each count changes on the same edge as the push or pop that alters it, and it stays unchanged when a push and a pop coincide.
- R6: A read of address 0 while the inbound queue is empty returns 0, removes nothing and sets the underflow flag.
- R7: A write to address 0 while the outbound queue is full is discarded and sets the overflow flag.
- R8: Both flags hold until software writes address 1 with bit 8 (underflow) or bit 9 (overflow) set. Writing 0 to those bits leaves the flags unchanged.
- R9: Addresses 5 to 7 read 0, and writes to addresses 2 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| dn_valid | output | 1 | Outbound word available |
| dn_ready | input | 1 | Logic side takes the outbound word |
| dn_data | output | DATA_W | Oldest outbound word |
| up_valid | input | 1 | Logic side offers an inbound word |
| up_ready | output | 1 | Inbound queue has room |
| up_data | input | DATA_W | Inbound word |

## Verification
The hardest situations to reach are full-queue collisions: a bus write that arrives while the outbound queue is full, possibly in the same cycle the logic side drains a word, and a bus read that races an inbound push into an empty queue. The random stimulus alternates between fill phases, which favour pushes and hold back the consumers, and drain phases, which do the reverse. Both queues therefore hit their full and empty boundaries many times under mixed traffic. Directed sequences then pin down the overflow drop, the zero returned on underflow, and clearing one flag without disturbing the other.

// File: rtl/mm_fifo_window.sv
module mm_fifo_window #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] tx_mem [DEPTH];
  logic [DATA_W-1:0] rx_mem [DEPTH];
  logic [PTR_W-1:0]  tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              udf_q, ovf_q;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  wire hit_data = bus_addr == '0;
  wire hit_stat = bus_addr == ADDR_W'(1);
  wire tx_full  = tx_cnt == FULL;
  wire tx_empty = tx_cnt == '0;
  wire rx_full  = rx_cnt == FULL;
  wire rx_empty = rx_cnt == '0;

  wire tx_push = bus_wr & hit_data & ~tx_full;
  wire tx_pop  = dn_valid & dn_ready;
  wire rx_push = up_valid & up_ready;
  wire rx_pop  = bus_rd & hit_data & ~rx_empty;
  wire udf_set = bus_rd & hit_data & rx_empty;
  wire ovf_set = bus_wr & hit_data & tx_full;
  wire udf_clr = bus_wr & hit_stat & bus_wdata[8];
  wire ovf_clr = bus_wr & hit_stat & bus_wdata[9];

  assign dn_valid = ~tx_empty;
  assign dn_data  = tx_mem[tx_rp];
  assign up_ready = ~rx_full;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[DATA_W-1:0];
    if (rx_push) rx_mem[rx_wp] <= up_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= step(tx_wp);
      if (tx_pop)  tx_rp <= step(tx_rp);
      if (rx_push) rx_wp <= step(rx_wp);
      if (rx_pop)  rx_rp <= step(rx_rp);
      tx_cnt <= tx_cnt + CNT_W'(tx_push) - CNT_W'(tx_pop);
      rx_cnt <= rx_cnt + CNT_W'(rx_push) - CNT_W'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      udf_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      udf_q <= udf_set | (udf_q & ~udf_clr);
      ovf_q <= ovf_set | (ovf_q & ~ovf_clr);
    end
  end

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (bus_addr)
      ADDR_W'(0): if (!rx_empty) rd_word[DATA_W-1:0] = rx_mem[rx_rp];
      ADDR_W'(1): begin
        rd_word[0] = rx_empty;
        rd_word[1] = tx_full;
        rd_word[2] = rx_full;
        rd_word[3] = tx_empty;
        rd_word[8] = udf_q;
        rd_word[9] = ovf_q;
      end
      ADDR_W'(2): rd_word = 32'(DEPTH);
      ADDR_W'(3): rd_word = 32'(rx_cnt);
      ADDR_W'(4): rd_word = 32'(tx_cnt);
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end
endmodule

module mm_fifo_window_chk #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [DATA_W-1:0] dn_data,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic              udf_q,
  input logic              ovf_q
);
  a_r2_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (tx_cnt == $past(tx_cnt) || tx_cnt == $past(tx_cnt) + 1'b1 || tx_cnt + 1'b1 == $past(tx_cnt)));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CNT_W'(DEPTH) && rx_cnt <= CNT_W'(DEPTH));

  a_r6_underflow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == '0 && rx_cnt == '0 |=> bus_rdata == '0 && udf_q);

  a_r7_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == '0 && tx_cnt == CNT_W'(DEPTH) |=> ovf_q);

  a_r8_sticky_udf: assert property (@(posedge clk) disable iff (!rst_n)
    udf_q && !(bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[8]) |=> udf_q);

  a_r8_sticky_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q && !(bus_wr && bus_addr == ADDR_W'(1) && bus_wdata[9]) |=> ovf_q);
endmodule

bind mm_fifo_window mm_fifo_window_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .udf_q(udf_q), .ovf_q(ovf_q)
);

// File: tb/mm_fifo_window_tb.sv
module mm_fifo_window_tb_top;
  localparam int DEPTH = 8;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic dn_valid, dn_ready = 1'b0;
  logic [DW-1:0] dn_data;
  logic up_valid = 1'b0, up_ready;
  logic [DW-1:0] up_data = '0;

  always #2.5 clk = ~clk;

  mm_fifo_window #(.DEPTH(DEPTH), .DATA_W(DW), .ADDR_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data));

  int checks = 0, fails = 0;
  logic [31:0] txq[$], rxq[$];
  bit m_udf = 0, m_ovf = 0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[0] = rxq.size() == 0;
    s[1] = txq.size() == DEPTH;
    s[2] = rxq.size() == DEPTH;
    s[3] = txq.size() == 0;
    s[8] = m_udf;
    s[9] = m_ovf;
    return s;
  endfunction

  function automatic string tag_of(logic [2:0] a, bit empty);
    case (a)
      3'd0: return empty ? "R6 underflow read" : "R3 data pop";
      3'd1: return "R4 status";
      3'd2: return "R5 depth";
      3'd3, 3'd4: return "R5 used count";
      default: return "R9 unmapped";
    endcase
  endfunction

  task automatic cyc(bit wr, bit rd, logic [2:0] a, logic [31:0] wd,
                     bit upv, logic [31:0] upd, bit dnr);
    logic [31:0] exp = '0;
    bit tx_pop, tx_push, rx_pop, rx_push, was_empty;
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    up_valid = upv; up_data = upd; dn_ready = dnr;
    #1;
    check("R2 dn_valid", 32'(dn_valid), 32'(txq.size() != 0));
    if (txq.size() != 0) check("R2 dn_data order", dn_data, txq[0]);
    check("R3 up_ready", 32'(up_ready), 32'(rxq.size() < DEPTH));
    was_empty = rxq.size() == 0;
    rx_pop = 0;
    case (a)
      3'd0: if (!was_empty) begin exp = rxq[0]; rx_pop = rd; end
      3'd1: exp = exp_status();
      3'd2: exp = DEPTH;
      3'd3: exp = rxq.size();
      3'd4: exp = txq.size();
      default: exp = '0;
    endcase
    tx_pop  = dnr && txq.size() != 0;
    tx_push = wr && a == 3'd0 && txq.size() < DEPTH;
    rx_push = upv && rxq.size() < DEPTH;
    if (wr && a == 3'd1) begin
      if (wd[8]) m_udf = 0;
      if (wd[9]) m_ovf = 0;
    end
    if (wr && a == 3'd0 && txq.size() == DEPTH) m_ovf = 1;
    if (rd && a == 3'd0 && was_empty) m_udf = 1;
    if (tx_pop) void'(txq.pop_front());
    if (tx_push) txq.push_back(wd);
    if (rx_pop) void'(rxq.pop_front());
    if (rx_push) rxq.push_back(upd);
    @(posedge clk);
    #1;
    if (rd) check(tag_of(a, was_empty), bus_rdata, exp);
  endtask

  task automatic idle(); cyc(0, 0, 3'd0, 0, 0, 0, 0); endtask
  task automatic rd(logic [2:0] a); cyc(0, 1, a, 0, 0, 0, 0); endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 reset dn_valid", 32'(dn_valid), 0);
    check("R1 reset up_ready", 32'(up_ready), 1);
    check("R1 reset rdata", bus_rdata, 0);
    rd(3'd1);
    check("R1 reset status", bus_rdata, 32'h9);
    rd(3'd2);

    // R7: fill outbound queue and overrun it
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 0, 3'd0, 32'hA000 + i, 0, 0, 0);
    rd(3'd4);
    check("R7 dropped count", bus_rdata, DEPTH);
    rd(3'd1);
    check("R7 overflow bit", bus_rdata, 32'h203);
    // R6: underflow on empty read
    rd(3'd0);
    check("R6 zero data", bus_rdata, 0);
    // R8: write 0 keeps flags, clear only overflow, then underflow
    cyc(1, 0, 3'd1, 32'h0, 0, 0, 0);
    rd(3'd1);
    cyc(1, 0, 3'd1, 32'h200, 0, 0, 0);
    rd(3'd1);
    check("R8 clear overflow only", bus_rdata, 32'h103);
    cyc(1, 0, 3'd1, 32'h100, 0, 0, 0);
    rd(3'd1);
    // R9: writes to other addresses ignored
    for (int a = 2; a < 8; a++) cyc(1, 0, 3'(a), 32'hFFFF_FFFF, 0, 0, 0);
    for (int a = 1; a < 8; a++) rd(3'(a));
    // drain and check order R2
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 0, 3'd0, 0, 0, 0, 1);
    // R3 + R5: push inbound while reading count
    for (int i = 0; i < DEPTH + 1; i++) cyc(0, 1, 3'd3, 0, 1, 32'hB000 + i, 0);
    for (int i = 0; i < DEPTH + 1; i++) rd(3'd0);

    for (int n = 0; n < 6000; n++) begin
      bit fill = ((n / 300) % 2) == 0;
      int r = $urandom % 100;
      bit wr = 0, rdv = 0;
      logic [2:0] a = 3'd0;
      if (r < 40) wr = 1;
      else if (r < 80) rdv = 1;
      if (($urandom % 10) == 0) a = 3'($urandom % 8);
      if (wr && a == 3'd1 && ($urandom % 4) != 0) wr = 0;
      if (fill && rdv && a == 3'd0 && ($urandom % 3) != 0) rdv = 0;
      if (!fill && wr && a == 3'd0 && ($urandom % 3) != 0) wr = 0;
      cyc(wr, rdv, a, $urandom, ($urandom % 4) < (fill ? 3 : 1), $urandom,
          ($urandom % 4) < (fill ? 1 : 3));
    end
    idle();
    rd(3'd1);
    finish_run();
  end
endmodule